// File: doc/BRIEF.md
# Hardware Call/Return Stack Sequencer

This block performs stack commands for a processor-like datapath: push a value, pop a value, call a subroutine, and return from one. It keeps a 64-bit stack pointer and a 64-bit program counter in registers. It reaches storage through one request/acknowledge memory port that handles one access at a time. The stack grows toward lower addresses and each entry is one 8-byte slot. A push first lowers the pointer and then stores. A pop first loads and then raises the pointer.

A call stores the caller's next-instruction address on the stack and moves the program counter to the call target. A return loads the saved address back into the program counter. Each command passes through four phases: idle, address formation, memory wait and commit. Pointer, counter and popped data change only in the commit phase, which follows the memory acknowledge. A command presented while the block is busy is dropped. A command that starts with an unaligned stack pointer is refused and an error flag is raised.

Top module: `stack_seq`

## Requirements
- R1: Push (cmd_op 2'b00) writes cmd_data at address sp-8 and leaves sp equal to the old sp minus 8.
- R2: Pop (cmd_op 2'b01) reads the slot at sp, presents that value on pop_data, and leaves sp equal to the old sp plus 8. Values come back in last-in, first-out order.
- R3: Call (cmd_op 2'b10) writes next_pc at address sp-8, lowers sp by 8, and loads call_target into pc.
- R4: Return (cmd_op 2'b11) reads the slot at sp, loads that value into pc, and raises sp by 8.
- R5: busy is high from the cycle after a command is accepted until the command has committed. A command presented while busy has no effect: it causes no memory access and no change to sp, pc or pop_data.
- R6: While a command is in progress, sp and pc keep their previous values, however long the memory acknowledge takes.
- R7: If sp is not a multiple of 8 when a command is presented in idle, the command performs no memory access, busy stays low, sp and pc are unchanged, and misalign_err rises. The flag is re-evaluated when the next command is presented.
- R8: After reset, sp equals RESET_SP, pc equals RESET_PC, and pop_data, busy, mem_req and misalign_err are all 0.
- R9: Each accepted command makes exactly one memory access. mem_req stays high until mem_ack, and mem_we is high only for push and call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| cmd_data | input | 64 | Value to push |
| call_target | input | 64 | Destination address for a call |
| next_pc | input | 64 | Address after the call, saved as return address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the slot |
| mem_wdata | output | 64 | Data to write |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| sp | output | 64 | Stack pointer |
| pc | output | 64 | Program counter |
| pop_data | output | 64 | Last popped value |
| busy | output | 1 | Command in progress |
| misalign_err | output | 1 | Last presented command was refused for an unaligned sp |

## Verification
The command mix is repeated for memory acknowledge latencies of 0 to 3 cycles. It covers four pushes, two nested calls, the two matching returns and four pops. Each sweep therefore shows that the slot address, the direction of the pointer step and the LIFO order do not depend on latency. Sampling sp and pc while the access is stalled separates a commit after the acknowledge from a commit before it. A command injected during a push, and another during a pop, is checked through the access count and through the value later popped, which shows that it was dropped. A second instance is reset with an unaligned pointer; it shows that a command is refused with no memory traffic.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_UPDATE
    } stk_state_e;

    function automatic logic op_descends(input stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction
endpackage

// File: rtl/stk_addr_unit.sv
module stk_addr_unit
    import stk_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int SLOT_BYTES = 8
) (
    input  stk_op_e          op,
    input  logic [XLEN-1:0]  sp_cur,
    output logic [XLEN-1:0]  acc_addr,
    output logic [XLEN-1:0]  sp_after,
    output logic             misaligned
);
    localparam int              ALIGN_BITS = $clog2(SLOT_BYTES);
    localparam logic [XLEN-1:0] SLOT_W     = XLEN'(SLOT_BYTES);

    logic [XLEN-1:0] sp_dn;
    logic [XLEN-1:0] sp_up;

    always_comb begin
        sp_dn      = sp_cur - SLOT_W;
        sp_up      = sp_cur + SLOT_W;
        acc_addr   = op_descends(op) ? sp_dn : sp_cur;
        sp_after   = op_descends(op) ? sp_dn : sp_up;
        misaligned = |sp_cur[ALIGN_BITS-1:0];
    end
endmodule

// File: rtl/stk_result_sel.sv
module stk_result_sel
    import stk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  stk_op_e          op,
    input  logic [XLEN-1:0]  rdata,
    input  logic [XLEN-1:0]  target,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  pop_cur,
    output logic [XLEN-1:0]  pc_next,
    output logic [XLEN-1:0]  pop_next
);
    always_comb begin
        pc_next  = pc_cur;
        pop_next = pop_cur;
        unique case (op)
            OP_CALL: pc_next  = target;
            OP_RET:  pc_next  = rdata;
            OP_POP:  pop_next = rdata;
            default: ;
        endcase
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stk_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter int              SLOT_BYTES = 8,
    parameter logic [XLEN-1:0] RESET_SP   = 64'h1000,
    parameter logic [XLEN-1:0] RESET_PC   = 64'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [XLEN-1:0]  cmd_data,
    input  logic [XLEN-1:0]  call_target,
    input  logic [XLEN-1:0]  next_pc,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  sp,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  pop_data,
    output logic             busy,
    output logic             misalign_err
);
    typedef struct packed {
        stk_state_e      state;
        stk_op_e         op;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] rdata;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] pop;
        logic            err;
    } regs_t;

    regs_t r_q, r_d;

    stk_op_e         op_sel;
    logic [XLEN-1:0] acc_addr, sp_after, pc_next, pop_next;
    logic            misaligned;

    assign op_sel = (r_q.state == ST_IDLE) ? stk_op_e'(cmd_op) : r_q.op;

    stk_addr_unit #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_addr (
        .op         (op_sel),
        .sp_cur     (r_q.sp),
        .acc_addr   (acc_addr),
        .sp_after   (sp_after),
        .misaligned (misaligned)
    );

    stk_result_sel #(.XLEN(XLEN)) u_res (
        .op       (r_q.op),
        .rdata    (r_q.rdata),
        .target   (r_q.target),
        .pc_cur   (r_q.pc),
        .pop_cur  (r_q.pop),
        .pc_next  (pc_next),
        .pop_next (pop_next)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.err = misaligned;
                    if (!misaligned) begin
                        r_d.op     = stk_op_e'(cmd_op);
                        r_d.wdata  = (stk_op_e'(cmd_op) == OP_CALL) ? next_pc : cmd_data;
                        r_d.target = call_target;
                        r_d.state  = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                r_d.addr  = acc_addr;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_ack) begin
                    r_d.rdata = mem_rdata;
                    r_d.state = ST_UPDATE;
                end
            end
            ST_UPDATE: begin
                r_d.sp    = sp_after;
                r_d.pc    = pc_next;
                r_d.pop   = pop_next;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.sp     <= RESET_SP;
            r_q.pc     <= RESET_PC;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req      = (r_q.state == ST_WAIT);
    assign mem_we       = mem_req && op_descends(r_q.op);
    assign mem_addr     = r_q.addr;
    assign mem_wdata    = r_q.wdata;
    assign sp           = r_q.sp;
    assign pc           = r_q.pc;
    assign pop_data     = r_q.pop;
    assign busy         = (r_q.state != ST_IDLE);
    assign misalign_err = r_q.err;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int XLEN       = 64,
    parameter int SLOT_BYTES = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic            misalign_err,
    input logic [XLEN-1:0] sp,
    input logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] SLOT_W = XLEN'(SLOT_BYTES);

    assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_we_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_hold_while_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(sp) && $stable(pc)));

    assert_sp_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> ((sp == $past(sp) - SLOT_W) || (sp == $past(sp) + SLOT_W)));

    assert_no_access_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> !mem_req);
endmodule

bind stack_seq stack_seq_chk #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_chk (.*);

// File: tb/stack_seq_test.sv
module stack_seq_test;
    import stk_pkg::*;

    localparam logic [63:0] RSP = 64'h1000;
    localparam logic [63:0] RPC = 64'h400;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        bad_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [63:0] cmd_data = '0, call_target = '0, next_pc = '0;
    logic        mem_req, mem_we, busy, misalign_err;
    logic [63:0] mem_addr, mem_wdata, sp, pc, pop_data;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic        b_req, b_we, b_busy, b_err;
    logic [63:0] b_addr, b_wdata, b_sp, b_pc, b_pop;

    stack_seq #(.RESET_SP(RSP), .RESET_PC(RPC)) uut (
        .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_data, .call_target, .next_pc,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .sp, .pc, .pop_data, .busy, .misalign_err
    );

    stack_seq #(.RESET_SP(64'h1004), .RESET_PC(RPC)) uut_bad (
        .clk, .rst_n, .cmd_valid(bad_valid), .cmd_op, .cmd_data, .call_target, .next_pc,
        .mem_req(b_req), .mem_we(b_we), .mem_addr(b_addr), .mem_wdata(b_wdata),
        .mem_ack(1'b0), .mem_rdata(64'h0),
        .sp(b_sp), .pc(b_pc), .pop_data(b_pop), .busy(b_busy), .misalign_err(b_err)
    );

    int checks = 0, fails = 0, cycles = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with programmable acknowledge latency
    logic [63:0] mem [16];
    int dly = 0, cnt = 0, n_acc = 0;
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (cnt >= dly) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[6:3]];
                if (mem_we) mem[mem_addr[6:3]] <= mem_wdata;
                n_acc     <= n_acc + 1;
                cnt       <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_up();
        end
    end

    task automatic run(input logic [1:0] op, input logic [63:0] d, input logic [63:0] tgt,
                       input logic [63:0] npc, input bit inject);
        logic [63:0] sp0, pc0;
        bit          held;
        int          acc0;
        @(negedge clk);
        sp0 = sp; pc0 = pc; acc0 = n_acc; held = 1'b1;
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; call_target = tgt; next_pc = npc;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R5 busy after accept", 64'(busy), 64'd1);
        if (inject) begin
            cmd_valid = 1'b1; cmd_op = 2'b00; cmd_data = 64'hDEAD_BEEF;
        end
        while (busy) begin
            if (sp !== sp0 || pc !== pc0) held = 1'b0;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        chk("R6 sp/pc held during access", 64'(held), 64'd1);
        chk("R9 one access per command", 64'(n_acc - acc0), 64'd1);
    endtask

    logic [63:0] exp_sp, exp_pc, v;
    logic [63:0] shadow [4];
    logic [63:0] rets [2];

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset sp", sp, RSP);
        chk("R8 reset pc", pc, RPC);
        chk("R8 reset pop_data", pop_data, 64'h0);
        chk("R8 reset busy/req/err", {61'h0, busy, mem_req, misalign_err}, 64'h0);
        rst_n = 1'b1;
        exp_sp = RSP; exp_pc = RPC;

        for (int d = 0; d < 4; d++) begin
            dly = d;
            for (int i = 0; i < 4; i++) begin
                v = (64'h1111_2222_3333_0000 * 64'(i + 1)) ^ 64'(d);
                run(2'b00, v, '0, '0, 1'b0);
                exp_sp -= 8;
                shadow[i] = v;
                chk("R1 push sp", sp, exp_sp);
                chk("R1 push slot", mem[exp_sp[6:3]], v);
            end
            for (int k = 0; k < 2; k++) begin
                v = 64'h2000 + 64'(d * 64 + k * 8);
                rets[k] = exp_pc + 4;
                run(2'b10, '0, v, rets[k], 1'b0);
                exp_sp -= 8;
                exp_pc = v;
                chk("R3 call sp", sp, exp_sp);
                chk("R3 call pc", pc, v);
                chk("R3 call saved addr", mem[exp_sp[6:3]], rets[k]);
            end
            for (int k = 1; k >= 0; k--) begin
                run(2'b11, '0, '0, '0, 1'b0);
                exp_sp += 8;
                exp_pc = rets[k];
                chk("R4 ret pc", pc, exp_pc);
                chk("R4 ret sp", sp, exp_sp);
            end
            for (int i = 3; i >= 0; i--) begin
                run(2'b01, '0, '0, '0, 1'b0);
                exp_sp += 8;
                chk("R2 pop data", pop_data, shadow[i]);
                chk("R2 pop sp", sp, exp_sp);
            end
            chk("R7 no error on aligned sp", 64'(misalign_err), 64'd0);
        end

        // R5: commands injected while busy are dropped
        dly = 2;
        run(2'b00, 64'hCAFE_0001, '0, '0, 1'b1);
        exp_sp -= 8;
        chk("R5 dropped cmd sp", sp, exp_sp);
        run(2'b01, '0, '0, '0, 1'b1);
        exp_sp += 8;
        chk("R5 dropped cmd pop value", pop_data, 64'hCAFE_0001);
        chk("R5 dropped cmd sp after pop", sp, exp_sp);
        chk("R5 pc untouched by dropped cmds", pc, exp_pc);

        // R7: unaligned start pointer on the second instance
        @(negedge clk);
        bad_valid = 1'b1; cmd_op = 2'b00; cmd_data = 64'h55;
        @(negedge clk);
        bad_valid = 1'b0;
        chk("R7 error raised", 64'(b_err), 64'd1);
        chk("R7 stays idle", 64'(b_busy), 64'd0);
        repeat (3) begin
            @(negedge clk);
            chk("R7 no memory request", 64'(b_req), 64'd0);
        end
        chk("R7 sp unchanged", b_sp, 64'h1004);
        chk("R7 pc unchanged", b_pc, RPC);

        finish_up();
    end
endmodule